// File: doc/BRIEF.md
# Nibble-Parallel Transmit Payload Input Port

This block sits at the transmit input of an E3 framer that runs from its own line-rate clock and follows an external frame reference. From the line clock it makes a nibble clock at one quarter of the rate and drives it out to the terminal equipment. The equipment presents a 4-bit payload nibble for each nibble period. The block samples that nibble at a fixed phase and turns it into a serial bit stream, one bit per line clock. It also marks the start of each frame on that stream with a strobe.

Frame timing comes from a free-running bit counter. The counter wraps at the end of every frame. A rising edge on the frame-reference input, after a two-flop synchroniser, restarts it. The first nibble slots of every frame belong to framer overhead. During those slots an indicator output tells the equipment to hold its data, and the block drops whatever is on the nibble pins. The serial stream carries zeros in those bit positions, so that a later stage can insert the overhead.

Top module: `nibble_tx_port`

## Requirements
- R1: `nib_clk_o` repeats a four-line-clock pattern: high for two cycles, then low for two cycles. Its rising edge marks the first bit period of each nibble slot.
- R2: The nibble on `nib_i` is captured only at the third rising line-clock edge after the rising edge of `nib_clk_o`. Values present at the other three edges of the slot have no effect on `ser_o`.
- R3: `ovh_ind_o` is high throughout nibble slots 0 to OH_BITS/4-1 of each frame and low in every other slot. Nibbles presented in those slots are discarded, and the matching serial bits are 0.
- R4: The nibble captured in slot k leaves on `ser_o` during slot k+1, most significant bit first, one bit per line clock.
- R5: `sof_o` is a one-cycle pulse. It is coincident with the first serial bit of a frame, which is bit period 4 of the frame timeline.
- R6: A rising edge on `fref_i` restarts the frame. The third rising clock edge after `fref_i` goes high begins slot 0, with `nib_clk_o` high. A level held high causes no further restart.
- R7: Without a frame-reference edge, the frame timeline wraps to slot 0 every FRAME_BITS line clocks, and `sof_o` fires again in the new frame.
- R8: While `rst` is high, `nib_clk_o`, `ovh_ind_o`, `ser_o` and `sof_o` are 0. The first clock edge after `rst` falls begins slot 0 of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-rate clock, the only timing reference |
| rst | input | 1 | Synchronous active-high reset |
| fref_i | input | 1 | Asynchronous frame reference; a rising edge restarts the frame |
| nib_i | input | 4 | Payload nibble from the terminal equipment |
| nib_clk_o | output | 1 | Nibble clock, line clock divided by four |
| ovh_ind_o | output | 1 | High during nibble slots reserved for overhead |
| ser_o | output | 1 | Serial payload stream, MSB of each nibble first |
| sof_o | output | 1 | Strobe on the first serial bit of a frame |

## Verification
The hardest situation to reach is a frame restart that lands at an awkward moment. This includes the load phase of a slot, a partly filled slot, and the last few bits before a natural wrap. In those cases a stale nibble or a stale start strobe could leak into the new frame. The bench fires synchronised reference pulses at random gaps, so the restart falls on every phase of the slot and of the frame. It adds one directed pulse just before the wrap and one long held-high level. To prove the sampling phase, it puts random values on the nibble pins at every edge except the capture edge.

// File: rtl/nibport_pkg.sv
package nibport_pkg;

    localparam int NIB_W    = 4;
    localparam int PHASE_W  = 2;

    // Phase within a nibble slot; the nibble clock rises entering phase 0.
    localparam logic [PHASE_W-1:0] CAP_PHASE  = 2'd2; // edge leaving it is the 3rd after the rise
    localparam logic [PHASE_W-1:0] LOAD_PHASE = 2'd3;

    typedef logic [NIB_W-1:0] nib_t;

    typedef struct packed {
        logic first;  // slot 0 of the frame
        logic ovh;    // slot reserved for overhead
        nib_t data;
    } slot_cap_t;

    function automatic logic nclk_level(input logic [PHASE_W-1:0] ph);
        return (ph < 2'd2);
    endfunction

endpackage

// File: rtl/nibport_timebase.sv
module nibport_timebase
    import nibport_pkg::*;
#(
    parameter int FRAME_BITS = 1536,
    parameter int OH_BITS    = 12,
    localparam int CNT_W     = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             nib_clk_o,
    output logic             ovh_o
);

    localparam logic [CNT_W-1:0] LAST   = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] OH_LIM = CNT_W'(OH_BITS);

    logic [CNT_W-1:0] cnt_q, cnt_next;

    always_comb begin
        if (restart_i || cnt_q == LAST) cnt_next = '0;
        else                             cnt_next = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= LAST;
            nib_clk_o <= 1'b0;
            ovh_o     <= 1'b0;
        end else begin
            cnt_q     <= cnt_next;
            nib_clk_o <= nclk_level(cnt_next[PHASE_W-1:0]);
            ovh_o     <= (cnt_next < OH_LIM);
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/nibport_fref_sync.sv
module nibport_fref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fref_i,
    output logic rise_o
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= fref_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[STAGES-2:0], fref_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= sync_q[STAGES-1];
    end

    assign rise_o = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/nibport_capture.sv
module nibport_capture
    import nibport_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic               ovh_i,
    input  logic               first_i,
    input  nib_t               nib_i,
    output logic               ser_o,
    output logic               sof_o
);

    slot_cap_t hold_q;
    nib_t      shift_q;
    logic      sof_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (phase_i == CAP_PHASE) begin
            hold_q <= '{first: first_i, ovh: ovh_i, data: nib_i};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            sof_q   <= 1'b0;
        end else if (phase_i == LOAD_PHASE) begin
            shift_q <= hold_q.ovh ? '0 : hold_q.data;
            sof_q   <= hold_q.first;
        end else begin
            shift_q <= {shift_q[NIB_W-2:0], 1'b0};
            sof_q   <= 1'b0;
        end
    end

    assign ser_o = shift_q[NIB_W-1];
    assign sof_o = sof_q;

endmodule

// File: rtl/nibble_tx_port.sv
module nibble_tx_port
    import nibport_pkg::*;
#(
    parameter int FRAME_BITS  = 1536,
    parameter int OH_BITS     = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fref_i,
    input  logic [3:0] nib_i,
    output logic       nib_clk_o,
    output logic       ovh_ind_o,
    output logic       ser_o,
    output logic       sof_o
);

    localparam int CNT_W = $clog2(FRAME_BITS);

    logic             restart_w;
    logic [CNT_W-1:0] cnt_w;
    logic             first_slot;

    nibport_fref_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .fref_i (fref_i),
        .rise_o (restart_w)
    );

    nibport_timebase #(.FRAME_BITS(FRAME_BITS), .OH_BITS(OH_BITS)) u_tbase (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restart_w),
        .cnt_o     (cnt_w),
        .nib_clk_o (nib_clk_o),
        .ovh_o     (ovh_ind_o)
    );

    assign first_slot = (cnt_w[CNT_W-1:PHASE_W] == '0);

    nibport_capture u_cap (
        .clk     (clk),
        .rst     (rst),
        .phase_i (cnt_w[PHASE_W-1:0]),
        .ovh_i   (ovh_ind_o),
        .first_i (first_slot),
        .nib_i   (nib_i),
        .ser_o   (ser_o),
        .sof_o   (sof_o)
    );

endmodule

// File: rtl/nibble_tx_port_chk.sv
module nibble_tx_port_chk #(
    parameter int FRAME_BITS = 1536,
    parameter int OH_BITS    = 12,
    localparam int CNT_W     = $clog2(FRAME_BITS)
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] cnt,
    input logic             restart,
    input logic             nib_clk,
    input logic             ovh,
    input logic             ser,
    input logic             sof
);

    localparam logic [CNT_W-1:0] LAST   = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] OH_LIM = CNT_W'(OH_BITS);

    // R1: a high nibble clock stays high for a second cycle
    assert_nclk_high_pair_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(nib_clk) |=> nib_clk);

    // R1: a falling nibble clock stays low for a second cycle unless restarted
    assert_nclk_low_pair_R1: assert property (@(posedge clk) disable iff (rst)
        ($fell(nib_clk) && !restart) |=> !nib_clk);

    // R3: the overhead indicator only covers the head of the frame
    assert_ovh_in_head_R3: assert property (@(posedge clk) disable iff (rst)
        ovh |-> (cnt < OH_LIM));

    // R5: frame strobe lasts a single cycle
    assert_sof_single_R5: assert property (@(posedge clk) disable iff (rst)
        sof |=> !sof);

    // R6: a synchronised reference edge begins slot 0 with the nibble clock high
    assert_restart_slot0_R6: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0) && nib_clk);

    // R7: the frame wraps by itself
    assert_frame_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        ((cnt == LAST) && !restart) |=> (cnt == '0));

    generate
        if (OH_BITS >= 4) begin : g_oh_zero
            // R3: the first serial bit of a frame sits in overhead and is zero
            assert_sof_bit_zero_R3: assert property (@(posedge clk) disable iff (rst)
                (sof && cnt == CNT_W'(4)) |-> !ser);
        end
    endgenerate

endmodule

bind nibble_tx_port nibble_tx_port_chk #(
    .FRAME_BITS (FRAME_BITS),
    .OH_BITS    (OH_BITS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cnt     (cnt_w),
    .restart (restart_w),
    .nib_clk (nib_clk_o),
    .ovh     (ovh_ind_o),
    .ser     (ser_o),
    .sof     (sof_o)
);

// File: tb/nibble_tx_port_bench.sv
module nibble_tx_port_bench;

    localparam int FRAME_BITS = 1536;
    localparam int OH_BITS    = 12;
    localparam int OH_SLOTS   = OH_BITS / 4;
    localparam int SEED       = 24681;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fref = 1'b0;
    logic [3:0] nib = 4'h0;
    logic       nib_clk_o, ovh_ind_o, ser_o, sof_o;

    always #10 clk = ~clk;

    nibble_tx_port #(.FRAME_BITS(FRAME_BITS), .OH_BITS(OH_BITS)) u_nibble_tx_port (
        .clk       (clk),
        .rst       (rst),
        .fref_i    (fref),
        .nib_i     (nib),
        .nib_clk_o (nib_clk_o),
        .ovh_ind_o (ovh_ind_o),
        .ser_o     (ser_o),
        .sof_o     (sof_o)
    );

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    int   e = 0;        // expected bit position in frame
    int   cd = 0;       // edges left until a pending restart
    bit   valid = 0;    // serial expectations known
    bit   wrapped = 0;
    bit   restarted = 0;
    logic [3:0] cur_nib = 4'h0, prev_nib = 4'h0;
    bit   cur_ovh = 1, prev_ovh = 1;

    task automatic chk(input int act, input int exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d pos=%0d t=%0t", req, act, exp, e, $time);
        end
    endtask

    function automatic int exp_ovh(input int pos);
        return ((pos / 4) < OH_SLOTS) ? 1 : 0;
    endfunction

    function automatic int exp_ser(input logic [3:0] n, input bit o, input int ph);
        return o ? 0 : int'(n[3 - ph]);
    endfunction

    task automatic cycle_step();
        int p;
        p = e % 4;
        if (p == 0) begin
            prev_nib = cur_nib;
            prev_ovh = cur_ovh;
            cur_nib  = 4'($urandom);
            cur_ovh  = exp_ovh(e) != 0;
        end
        if (e == 4) valid = 1;
        chk(int'(nib_clk_o), (p < 2) ? 1 : 0, "R1");
        chk(int'(ovh_ind_o), exp_ovh(e), "R3");
        if (restarted) begin
            chk(int'(nib_clk_o), 1, "R6");
            chk(int'(ovh_ind_o), (OH_SLOTS > 0) ? 1 : 0, "R6");
            restarted = 0;
        end
        if (wrapped && e == 0) chk(int'(nib_clk_o), 1, "R7");
        if (valid) begin
            chk(int'(ser_o), exp_ser(prev_nib, prev_ovh, p), prev_ovh ? "R3" : "R2 R4");
            chk(int'(sof_o), (e == 4) ? 1 : 0, "R5");
            if (wrapped && e == 4) begin
                chk(int'(sof_o), 1, "R7");
                wrapped = 0;
            end
        end
        // real data only across the capture edge; noise elsewhere (R2)
        nib = (p == 2) ? cur_nib : 4'($urandom);
        @(posedge clk);
        if (cd > 0) begin
            cd--;
            if (cd == 0) begin
                e = 0;
                valid = 0;
                wrapped = 0;
                restarted = 1;
            end else begin
                if (e == FRAME_BITS - 1) begin e = 0; wrapped = 1; end
                else e++;
            end
        end else begin
            if (e == FRAME_BITS - 1) begin e = 0; wrapped = 1; end
            else e++;
        end
        @(negedge clk);
    endtask

    task automatic run(input int n);
        repeat (n) cycle_step();
    endtask

    task automatic pulse_ref();
        fref = 1'b1;
        cd = 3;
        run(1);
        fref = 1'b0;
        run(8);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        void'($urandom(SEED));
        rst = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk(int'(nib_clk_o), 0, "R8");
            chk(int'(ovh_ind_o), 0, "R8");
            chk(int'(ser_o), 0, "R8");
            chk(int'(sof_o), 0, "R8");
        end
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        e = 0;
        chk(int'(nib_clk_o), 1, "R8");
        chk(int'(ovh_ind_o), 1, "R8");

        // free running across two natural wraps
        run(2 * FRAME_BITS + 50);

        // directed: restart just before the frame end
        while (e != FRAME_BITS - 3) run(1);
        pulse_ref();
        run(400);

        // random restart positions within slot and frame
        repeat (6) begin
            run(200 + int'($urandom % 1500));
            pulse_ref();
            run(20);
        end

        // level held high: one restart only
        fref = 1'b1;
        cd = 3;
        run(600);
        fref = 1'b0;
        run(100);

        // wrap after a restart
        run(FRAME_BITS + 20);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule